// File: doc/BRIEF.md
# Timer-Shared Port Data Register

This block is a small data register for a group of pins that timer channels share with plain general-purpose I/O. Each pin is governed by a direction bit and by a timer-ownership bit. A bus write always lands in an internal data latch. That latch only steers a pin when the pin is a general-purpose output. While a timer channel owns a pin, its compare output drives the pin, and writes to the latch have no visible effect on that pin.

Readback is per pin. A pin configured as an input returns its sensed level, taken through a two-flop synchronizer. A pin configured as an output returns the latched value. The register sits in the low nibble of a byte-wide bus word. The upper nibble reads as zero and ignores writes. Any bit may be read or written at any time.

Top module: `tmr_port_reg`

## Requirements
- R1: While reset is asserted and just after it is released, the latch and the synchronizer hold zero, so rd_data reads 0x00.
- R2: A cycle with wr_en high loads wr_data[3:0] into the latch at that rising edge, whatever the direction and timer-ownership bits are. With wr_en low the latch holds its value.
- R3: When tmr_en[i] is 0, pin_drv[i] equals latch bit i. It therefore follows a write from the rising edge that performs the write.
- R4: When tmr_en[i] is 1, pin_drv[i] equals tmr_out[i], and a write does not change pin_drv[i].
- R5: pin_oe[i] is 1 when tmr_en[i] is 1 or dir[i] is 1, and 0 otherwise.
- R6: When dir[i] is 0, rd_data[i] returns pin_in[i] as sampled two rising edges earlier (two-flop synchronizer).
- R7: When dir[i] is 1, rd_data[i] returns latch bit i.
- R8: rd_data[7:4] is always 0, and wr_data[7:4] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the data latch |
| wr_data | input | 8 | Write data; bits 3:0 are used |
| rd_data | output | 8 | Readback; bits 7:4 are zero |
| dir | input | 4 | Direction per pin, 1 = output |
| tmr_en | input | 4 | Timer channel owns the pin as an output |
| tmr_out | input | 4 | Timer compare output level per pin |
| pin_in | input | 4 | Sensed pin levels (asynchronous) |
| pin_drv | output | 4 | Level driven onto each pin |
| pin_oe | output | 4 | Output enable per pin |

## Verification
pin_oe follows dir and tmr_en combinationally, in the same cycle. pin_drv and the readback of output pins change at the rising edge that captures a write. The readback of input pins lags pin_in by two rising edges. The bench applies stimulus on falling edges and keeps a cycle-accurate model of the latch and of both synchronizer stages. After each rising edge it queues the expected rd_data, pin_drv and pin_oe. A monitor pops that item one time unit after the edge, once the registers have settled, so every comparison lands in the cycle where the requirement says the result is due.

// File: rtl/tmr_port_pkg.sv
package tmr_port_pkg;
  localparam int PORT_W = 4;
  localparam int BUS_W  = 8;

  // Driver selection: the timer wins when it owns the pin.
  function automatic logic drive_pick(input logic owned, input logic tmr_lvl,
                                      input logic latch_lvl);
    return owned ? tmr_lvl : latch_lvl;
  endfunction

  // Readback selection: outputs show the latch, inputs show the sensed level.
  function automatic logic read_pick(input logic is_out, input logic latch_lvl,
                                     input logic sensed_lvl);
    return is_out ? latch_lvl : sensed_lvl;
  endfunction

  function automatic logic enable_pick(input logic owned, input logic is_out);
    return owned | is_out;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
    end
    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/port_latch.sv
module port_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/tmr_port_reg.sv
module tmr_port_reg
  import tmr_port_pkg::*;
#(
  parameter int P_W   = PORT_W,
  parameter int B_W   = BUS_W,
  parameter int SYNCN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [B_W-1:0] wr_data,
  output logic [B_W-1:0] rd_data,
  input  logic [P_W-1:0] dir,
  input  logic [P_W-1:0] tmr_en,
  input  logic [P_W-1:0] tmr_out,
  input  logic [P_W-1:0] pin_in,
  output logic [P_W-1:0] pin_drv,
  output logic [P_W-1:0] pin_oe
);
  localparam int RSV_W = B_W - P_W;

  logic [P_W-1:0] latch_q;
  logic [P_W-1:0] sensed;
  logic [P_W-1:0] rd_port;
  logic           unused_hi;

  assign unused_hi = ^wr_data[B_W-1:P_W];

  port_latch #(.W(P_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(wr_en), .d(wr_data[P_W-1:0]), .q(latch_q)
  );

  pin_sync #(.W(P_W), .STAGES(SYNCN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sensed)
  );

  for (genvar i = 0; i < P_W; i++) begin : g_pin
    assign pin_drv[i] = drive_pick(tmr_en[i], tmr_out[i], latch_q[i]);
    assign pin_oe[i]  = enable_pick(tmr_en[i], dir[i]);
    assign rd_port[i] = read_pick(dir[i], latch_q[i], sensed[i]);

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tmr_en[i]) |=> (tmr_en[i] || pin_drv[i] == $past(wr_data[i])));
    // R4
    tmr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tmr_en[i]) |=>
        (!(tmr_en[i] && tmr_out[i] == $past(tmr_out[i])) ||
         pin_drv[i] == $past(pin_drv[i])));
    // R7
    out_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dir[i]) |=> (!dir[i] || rd_data[i] == $past(wr_data[i])));
  end

  assign rd_data = {{RSV_W{1'b0}}, rd_port};
endmodule

// File: tb/tmr_port_reg_tb_top.sv
module tmr_port_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] dir = '0, tmr_en = '0, tmr_out = '0, pin_in = '0;
  logic [3:0] pin_drv, pin_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_port_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dir(dir), .tmr_en(tmr_en), .tmr_out(tmr_out),
    .pin_in(pin_in), .pin_drv(pin_drv), .pin_oe(pin_oe)
  );

  typedef struct {
    logic [7:0] rd;
    logic [3:0] drv;
    logic [3:0] oe;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // bench model state
  logic [3:0] m_lat = '0, m_s1 = '0, m_s2 = '0;

  task automatic step(input logic we, input logic [7:0] wd, input logic [3:0] dr,
                      input logic [3:0] te, input logic [3:0] to,
                      input logic [3:0] pi, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; dir = dr; tmr_en = te; tmr_out = to; pin_in = pi;
    m_s2 = m_s1;
    m_s1 = pi;
    if (we) m_lat = wd[3:0];
    e.rd  = {4'h0, (dr & m_lat) | (~dr & m_s2)};
    e.drv = (te & to) | (~te & m_lat);
    e.oe  = te | dr;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "rd_data", rd_data, e.rd);
        cmp(e.tag, "pin_drv", {4'h0, pin_drv}, {4'h0, e.drv});
        cmp(e.tag, "pin_oe",  {4'h0, pin_oe},  {4'h0, e.oe});
      end
    end
  end

  initial begin
    // R1 reset state
    pin_in = 4'hF; wr_en = 1'b1; wr_data = 8'hFF;
    repeat (3) @(negedge clk);
    cmp("R1", "rd_data in reset", rd_data, 8'h00);
    wr_en = 1'b0; pin_in = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, "R1");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, "R1");
    // R2 R3 R7 R8: outputs, write with upper nibble set
    step(1'b1, 8'hA5, 4'hF, 4'h0, 4'h0, 4'h0, "R2");
    step(1'b0, 8'h00, 4'hF, 4'h0, 4'h0, 4'h0, "R3");
    step(1'b1, 8'hF0, 4'hF, 4'h0, 4'h0, 4'h0, "R8");
    step(1'b1, 8'h3A, 4'hF, 4'h0, 4'h0, 4'h0, "R7");
    // R6 inputs through synchronizer
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h9, "R6");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h6, "R6");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'hF, "R6");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
    // R4 timer owns pins, writes hidden on pins but latched
    step(1'b0, 8'h00, 4'hF, 4'hF, 4'h3, 4'h0, "R4");
    step(1'b1, 8'h0C, 4'hF, 4'hF, 4'h3, 4'h0, "R4");
    step(1'b0, 8'h00, 4'hF, 4'hF, 4'h6, 4'h0, "R4");
    step(1'b0, 8'h00, 4'hF, 4'h0, 4'h6, 4'h0, "R2");
    // R5 mixed ownership and direction
    step(1'b0, 8'h00, 4'h3, 4'h4, 4'hF, 4'hA, "R5");
    step(1'b1, 8'h05, 4'h3, 4'h4, 4'hF, 4'h5, "R5");
    step(1'b0, 8'h00, 4'h3, 4'h4, 4'h0, 4'h5, "R5");
    step(1'b0, 8'h00, 4'hC, 4'h1, 4'h1, 4'h5, "R5");
    step(1'b1, 8'hFA, 4'h5, 4'h2, 4'h0, 4'h3, "R8");
    step(1'b0, 8'h00, 4'h5, 4'h2, 4'h2, 4'h3, "R7");
    step(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 4'h3, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule